// File: doc/BRIEF.md
# I2C Slave Address Detector

This block watches an I2C bus from the slave side. It finds START and STOP conditions, collects the first byte sent after each START, and decides whether that byte selects this device. The byte selects the device when its upper seven bits equal a programmable own address. It also selects the device when the whole byte is zero, which is the general call. On a hit the block pulls SDA low for the acknowledge clock, raises a sticky access flag and records the direction bit. A transfer-busy indication stays low from a START until the matching STOP.

Software controls the block through two pulse inputs. One enables it and the other disables it. While disabled, the block ignores the bus completely. The sticky flags are cleared by a status-read strobe, but only when no transfer is in progress. Anything after the address acknowledge belongs to a separate data-phase engine.

Top module: `i2c_addr_detect`

## Requirements
- R1: After reset, `slv_acc_o`, `gc_acc_o`, `rd_dir_o` and `sda_pull_o` are 0 and `idle_o` is 1. The block starts disabled.
- R2: A pulse on `en_set_i` enables the block only when `dis_set_i` is low in the same cycle, and `dis_set_i` disables it. While disabled, the block never pulls SDA, sets no flag and holds `idle_o` at 1.
- R3: While enabled, SDA falling with SCL high is a START and drops `idle_o`. SDA rising with SCL high is a STOP and raises `idle_o`. Each change shows three clock cycles after the bus edge is sampled, because both lines pass through a two-flop synchroniser.
- R4: The first eight bits after a START are sampled on SCL rising edges, most significant bit first. When bits 7..1 equal `own_addr_i`, `slv_acc_o` sets at the SCL falling edge that ends the eighth bit, and `rd_dir_o` takes bit 0 (1 = read, 0 = write).
- R5: A received byte of 0x00 sets `gc_acc_o`. A byte of 0x01 is not a general call.
- R6: On a hit, `sda_pull_o` rises at the falling edge of the eighth SCL clock. It falls after the falling edge of the ninth clock. On a miss, SDA is never pulled.
- R7: A `stat_rd_i` strobe taken while `idle_o` is 1 clears `slv_acc_o`, `gc_acc_o` and `rd_dir_o`. A strobe taken while `idle_o` is 0 leaves them unchanged.
- R8: A START that arrives during a transfer restarts address collection from the first bit.
- R9: A disable pulse during the acknowledge clock releases SDA and raises `idle_o` on the following clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| own_addr_i | input | ADDR_W | Programmed device address |
| en_set_i | input | 1 | Enable strobe |
| dis_set_i | input | 1 | Disable strobe, dominant |
| stat_rd_i | input | 1 | Status read strobe |
| sda_pull_o | output | 1 | 1 = drive SDA low |
| slv_acc_o | output | 1 | Sticky own-address hit |
| gc_acc_o | output | 1 | Sticky general-call hit |
| rd_dir_o | output | 1 | Direction of the last own-address hit |
| idle_o | output | 1 | 1 = no transfer in progress |

## Verification
A corrupted shift register or bit counter shows on the bus within one byte. Either the acknowledge appears on a mismatch, or it is missing on a match, at the ninth SCL pulse. A lost state-machine state shows the same way, or as `sda_pull_o` held past the ninth falling edge. A wrong enable or busy state shows as `idle_o` or a flag that differs from the per-cycle reference model within three cycles of the bus edge that should have moved it. Status reads are issued both mid-transfer and after STOP, so a flag cleared at the wrong time differs on the very next clock.

// File: rtl/i2c_adet_pkg.sv
package i2c_adet_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ADDR = 3'd1,
      ST_CHK  = 3'd2,
      ST_ACK  = 3'd3,
      ST_WAIT = 3'd4
   } adet_state_e;

   // bus lines idle high; synchroniser and edge history reset to it
   localparam logic BUS_IDLE = 1'b1;
endpackage

// File: rtl/i2c_adet_sync.sv
module i2c_adet_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   import i2c_adet_pkg::*;

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_adet_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_st
      logic [W-1:0] q;
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= {W{BUS_IDLE}};
            else        q <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= {W{BUS_IDLE}};
            else        q <= g_st[g-1].q;
         end
      end
   end

   assign q_o = g_st[STAGES-1].q;
endmodule

// File: rtl/i2c_adet_cond.sv
module i2c_adet_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic start_o,
   output logic stop_o,
   output logic rise_o,
   output logic fall_o
);
   import i2c_adet_pkg::*;

   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= BUS_IDLE;
         sda_d <= BUS_IDLE;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign start_o = scl_s &  sda_d & ~sda_s;
   assign stop_o  = scl_s & ~sda_d &  sda_s;
   assign rise_o  = scl_s & ~scl_d;
   assign fall_o  = ~scl_s & scl_d;
endmodule

// File: rtl/i2c_adet_match.sv
module i2c_adet_match #(
   parameter int ADDR_W = 7,
   parameter bit GC_EN  = 1'b1
) (
   input  logic [ADDR_W:0]   frame_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   output logic              sv_hit_o,
   output logic              gc_hit_o
);
   assign sv_hit_o = (frame_i[ADDR_W:1] == own_addr_i);

   if (GC_EN) begin : g_gc
      assign gc_hit_o = (frame_i == '0);
   end else begin : g_no_gc
      assign gc_hit_o = 1'b0;
   end
endmodule

// File: rtl/i2c_addr_detect.sv
module i2c_addr_detect #(
   parameter int ADDR_W      = 7,
   parameter int SYNC_STAGES = 2,
   parameter bit GC_EN       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic              en_set_i,
   input  logic              dis_set_i,
   input  logic              stat_rd_i,
   output logic              sda_pull_o,
   output logic              slv_acc_o,
   output logic              gc_acc_o,
   output logic              rd_dir_o,
   output logic              idle_o
);
   import i2c_adet_pkg::*;

   localparam int FRAME_W = ADDR_W + 1;
   localparam int CNT_W   = $clog2(FRAME_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr_w
      $error("i2c_addr_detect: ADDR_W out of range 1..10");
   end

   logic [1:0]         sync_q;
   logic               scl_s, sda_s;
   logic               start_w, stop_w, rise_w, fall_w;
   logic               sv_hit, gc_hit, ack_go;
   logic               enabled;
   adet_state_e        state;
   logic [CNT_W-1:0]   bit_cnt;
   logic [ADDR_W:0]    frame;

   i2c_adet_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(sync_q)
   );
   assign scl_s = sync_q[1];
   assign sda_s = sync_q[0];

   i2c_adet_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .start_o(start_w), .stop_o(stop_w), .rise_o(rise_w), .fall_o(fall_w)
   );

   i2c_adet_match #(.ADDR_W(ADDR_W), .GC_EN(GC_EN)) u_match (
      .frame_i(frame), .own_addr_i(own_addr_i),
      .sv_hit_o(sv_hit), .gc_hit_o(gc_hit)
   );

   // acknowledge decision: end of the last address bit, bus still owned
   assign ack_go = enabled && !dis_set_i && !stop_w && !start_w &&
                   (state == ST_CHK) && fall_w && (sv_hit || gc_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         enabled <= 1'b0;
      else if (dis_set_i) enabled <= 1'b0;
      else if (en_set_i)  enabled <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         bit_cnt    <= '0;
         frame      <= '0;
         sda_pull_o <= 1'b0;
         idle_o     <= 1'b1;
      end else if (dis_set_i || !enabled || stop_w) begin
         state      <= ST_IDLE;
         sda_pull_o <= 1'b0;
         idle_o     <= 1'b1;
      end else if (start_w) begin
         state      <= ST_ADDR;
         bit_cnt    <= '0;
         sda_pull_o <= 1'b0;
         idle_o     <= 1'b0;
      end else begin
         unique case (state)
            ST_ADDR: if (rise_w) begin
               frame <= {frame[ADDR_W-1:0], sda_s};
               if (bit_cnt == LAST_BIT) state <= ST_CHK;
               else                     bit_cnt <= bit_cnt + 1'b1;
            end
            ST_CHK: if (fall_w) begin
               if (ack_go) begin
                  sda_pull_o <= 1'b1;
                  state      <= ST_ACK;
               end else begin
                  state <= ST_WAIT;
               end
            end
            ST_ACK: if (fall_w) begin
               sda_pull_o <= 1'b0;
               state      <= ST_WAIT;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slv_acc_o <= 1'b0;
         gc_acc_o  <= 1'b0;
         rd_dir_o  <= 1'b0;
      end else if (ack_go) begin
         slv_acc_o <= slv_acc_o | sv_hit;
         gc_acc_o  <= gc_acc_o | gc_hit;
         if (sv_hit) rd_dir_o <= frame[0];
      end else if (stat_rd_i && idle_o) begin
         slv_acc_o <= 1'b0;
         gc_acc_o  <= 1'b0;
         rd_dir_o  <= 1'b0;
      end
   end

   // R6
   pull_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sda_pull_o |-> !idle_o);
   // R6
   pull_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull_o) |-> (slv_acc_o || gc_acc_o));
   // R7
   sv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(slv_acc_o) |-> $past(stat_rd_i && idle_o));
   // R7
   gc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gc_acc_o) |-> $past(stat_rd_i && idle_o));
   // R9
   dis_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dis_set_i |=> (!sda_pull_o && idle_o));
   // R2
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enabled |=> (!sda_pull_o && $stable(slv_acc_o | gc_acc_o) || !slv_acc_o && !gc_acc_o));
endmodule

// File: tb/i2c_addr_detect_tb.sv
module i2c_addr_detect_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int H          = 8;
   localparam int WD_CYCLES  = 150000;
   localparam logic [6:0] OWN = 7'h3A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1, m_sda = 1'b1;
   logic en_set = 1'b0, dis_set = 1'b0, stat_rd = 1'b0;
   logic sda_pull, slv_acc, gc_acc, rd_dir, idle;
   wire  sda_bus = m_sda & ~sda_pull;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_addr_detect dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
      .own_addr_i(OWN), .en_set_i(en_set), .dis_set_i(dis_set),
      .stat_rd_i(stat_rd), .sda_pull_o(sda_pull), .slv_acc_o(slv_acc),
      .gc_acc_o(gc_acc), .rd_dir_o(rd_dir), .idle_o(idle)
   );

   // ---------------- behavioural reference ----------------
   bit sq[$] = '{1, 1, 1};
   bit dq[$] = '{1, 1, 1};
   bit e_pull = 0, e_acc = 0, e_gc = 0, e_rd = 0, e_idle = 1, m_en = 0;
   int e_mode = 0;   // 0 idle 1 collect 2 decide 3 ack 4 wait
   int e_cnt = 0, e_byte = 0;
   bit started = 0;

   always @(posedge clk) begin
      bit cs, cd, os, od, st, sp, ri, fa, hs, hg, go, old_idle, bus;
      if (!rst_n) begin
         sq = '{1, 1, 1}; dq = '{1, 1, 1};
         e_pull = 0; e_acc = 0; e_gc = 0; e_rd = 0; e_idle = 1; m_en = 0;
         e_mode = 0; e_cnt = 0; e_byte = 0;
      end else begin
         started = 1;
         cs = sq[1]; cd = dq[1]; os = sq[2]; od = dq[2];
         st = cs && od && !cd; sp = cs && !od && cd;
         ri = cs && !os; fa = !cs && os;
         bus = m_sda & ~e_pull;
         sq.push_front(m_scl); void'(sq.pop_back());
         dq.push_front(bus);   void'(dq.pop_back());
         go = 0; hs = 0; hg = 0; old_idle = e_idle;
         if (dis_set || !m_en || sp) begin
            e_mode = 0; e_pull = 0; e_idle = 1;
         end else if (st) begin
            e_mode = 1; e_cnt = 0; e_pull = 0; e_idle = 0;
         end else begin
            case (e_mode)
               1: if (ri) begin
                     e_byte = ((e_byte << 1) | int'(cd)) & 255;
                     if (e_cnt == 7) e_mode = 2; else e_cnt++;
                  end
               2: if (fa) begin
                     hs = ((e_byte >> 1) == int'(OWN));
                     hg = (e_byte == 0);
                     if (hs || hg) begin go = 1; e_pull = 1; e_mode = 3; end
                     else e_mode = 4;
                  end
               3: if (fa) begin e_pull = 0; e_mode = 4; end
               default: ;
            endcase
         end
         if (go) begin
            e_acc = e_acc | hs; e_gc = e_gc | hg;
            if (hs) e_rd = e_byte[0];
         end else if (stat_rd && old_idle) begin
            e_acc = 0; e_gc = 0; e_rd = 0;
         end
         if (dis_set) m_en = 0; else if (en_set) m_en = 1;
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (started) begin
         chk("R6 sda_pull_o (per cycle)", sda_pull, e_pull);
         chk("R4 slv_acc_o (per cycle)", slv_acc, e_acc);
         chk("R5 gc_acc_o (per cycle)", gc_acc, e_gc);
         chk("R4 rd_dir_o (per cycle)", rd_dir, e_rd);
         chk("R3 idle_o (per cycle)", idle, e_idle);
      end
   end

   // ---------------- bus master tasks ----------------
   task automatic wait_h();
      repeat (H) @(negedge clk);
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      if (which == 0) en_set = 1;
      if (which == 1) dis_set = 1;
      if (which == 2) begin en_set = 1; dis_set = 1; end
      if (which == 3) stat_rd = 1;
      @(negedge clk);
      en_set = 0; dis_set = 0; stat_rd = 0;
      repeat (2) @(negedge clk);
   endtask

   task automatic bus_start();
      m_scl = 0; wait_h(); m_sda = 1; wait_h();
      m_scl = 1; wait_h(); m_sda = 0; wait_h();
   endtask

   task automatic bus_stop();
      m_scl = 0; wait_h(); m_sda = 0; wait_h();
      m_scl = 1; wait_h(); m_sda = 1; wait_h();
   endtask

   task automatic send_bit(input logic b);
      m_scl = 0; wait_h(); m_sda = b; wait_h(); m_scl = 1; wait_h();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      m_scl = 0; wait_h(); m_sda = 1; wait_h(); m_scl = 1; wait_h();
      ack = sda_bus;
      wait_h();
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      logic ack;
      repeat (3) @(negedge clk);
      rst_n = 1;
      repeat (2) @(negedge clk);
      // R1 reset state
      chk("R1 idle_o", idle, 1);
      chk("R1 slv_acc_o", slv_acc, 0);
      chk("R1 sda_pull_o", sda_pull, 0);

      // R2 disabled: matching address gets no response
      bus_start(); send_byte(8'h74, ack); 
      chk("R2 no ack while disabled", ack, 1);
      chk("R2 idle_o held while disabled", idle, 1);
      bus_stop();

      // R2 enable with simultaneous disable has no effect
      pulse(2);
      bus_start(); send_byte(8'h74, ack);
      chk("R2 en+dis keeps block off", ack, 1);
      bus_stop();

      pulse(0);
      // R4 R6 write access to own address
      bus_start();
      chk("R3 idle_o low after START", idle, 0);
      send_byte(8'h74, ack);
      chk("R6 ack on own address", ack, 0);
      chk("R4 slv_acc_o set", slv_acc, 1);
      chk("R4 rd_dir_o write", rd_dir, 0);
      pulse(3);
      chk("R7 read while busy keeps flag", slv_acc, 1);
      bus_stop();
      chk("R3 idle_o high after STOP", idle, 1);
      pulse(3);
      chk("R7 read while idle clears flag", slv_acc, 0);

      // R4 read access
      bus_start(); send_byte(8'h75, ack);
      chk("R6 ack on read access", ack, 0);
      chk("R4 rd_dir_o read", rd_dir, 1);
      bus_stop(); pulse(3);

      // R6 mismatch
      bus_start(); send_byte(8'h44, ack);
      chk("R6 no ack on mismatch", ack, 1);
      chk("R6 no flag on mismatch", slv_acc | gc_acc, 0);
      bus_stop();

      // R5 general call
      bus_start(); send_byte(8'h00, ack);
      chk("R5 ack on general call", ack, 0);
      chk("R5 gc_acc_o set", gc_acc, 1);
      chk("R5 slv_acc_o clear on general call", slv_acc, 0);
      bus_stop(); pulse(3);
      chk("R7 gc_acc_o cleared", gc_acc, 0);
      bus_start(); send_byte(8'h01, ack);
      chk("R5 0x01 not a general call", ack, 1);
      chk("R5 gc_acc_o stays clear", gc_acc, 0);
      bus_stop();

      // R8 repeated START
      bus_start(); send_byte(8'h44, ack);
      bus_start(); send_byte(8'h74, ack);
      chk("R8 ack after repeated START", ack, 0);
      chk("R8 slv_acc_o after repeated START", slv_acc, 1);
      bus_stop(); pulse(3);

      // R9 disable during acknowledge
      bus_start();
      for (int i = 7; i >= 0; i--) send_bit(8'h74 >> i);
      m_scl = 0; wait_h(); m_sda = 1; wait_h(); m_scl = 1; wait_h();
      chk("R6 pull held in ninth clock", sda_pull, 1);
      @(negedge clk); dis_set = 1;
      @(negedge clk); dis_set = 0;
      chk("R9 pull released on disable", sda_pull, 0);
      chk("R9 idle_o raised on disable", idle, 1);
      bus_stop();
      repeat (4) @(negedge clk);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule